// File: doc/BRIEF.md
# Converter Fault and Power-Good Supervisor

This block watches the output of a synchronous buck controller through comparator flags that analog circuits produce elsewhere. The flags report an output above the over-voltage limit (+16% of the set point), below the under-voltage limit (-30%), or below the power-good floor (-10%), and a die that is too hot. The block also receives a soft-start-done flag, the enable input, a supply-valid flag and a one-cycle tick once per microsecond.

Each output condition must persist for a fixed number of ticks before it counts. The default is 5 ticks, or 5 µs. An over-voltage fault latches the low-side switch on. An under-voltage fault latches both gate drivers into high impedance. Either fault stops switching, and only a drop of enable or of supply-valid clears it.

Power-good follows a filtered window and stays low until soft-start has finished. Over-temperature stops switching without latching. With enable low, the output discharge switch turns on.

Top module: `conv_supervisor`

## Requirements
- R1: `pgood` goes low one clock after a window violation (`ov_flag` or `pg_low_flag` high) has lasted through FILT_TICKS ticks. It goes high again two clocks after the violation clears, provided no fault is latched.
- R2: `pgood` stays low while `ss_done` is low, even when every flag is inside the window.
- R3: A condition that clears before its FILT_TICKS-th tick has no effect on any output. Its count restarts from zero.
- R4: A filtered over-voltage latches `low_on`=1, `hiz`=0, `switch_en`=0 and `pgood`=0. The latch holds after `ov_flag` clears.
- R5: A filtered under-voltage latches `hiz`=1, `low_on`=0, `switch_en`=0 and `pgood`=0.
- R6: The under-voltage filter is held at zero while `ss_done` is low, so `uv_flag` has no effect before soft-start completes.
- R7: A latched fault stays latched while `en` and `supply_ok` are both high. It clears one clock after either one goes low.
- R8: `discharge_en` equals the inverse of `en`, one clock late.
- R9: `switch_en` goes low one clock after `ot_flag` rises and returns one clock after it falls. Nothing is latched.
- R10: If over- and under-voltage qualify in the same clock, the over-voltage fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| en | input | 1 | Converter enable |
| supply_ok | input | 1 | Analog supply valid |
| ss_done | input | 1 | Soft-start complete |
| ov_flag | input | 1 | Output above +16% |
| uv_flag | input | 1 | Output below -30% |
| pg_low_flag | input | 1 | Output below -10% |
| ot_flag | input | 1 | Over-temperature |
| pgood | output | 1 | Power good |
| switch_en | output | 1 | Switching allowed |
| low_on | output | 1 | Force low-side switch on (over-voltage latch) |
| hiz | output | 1 | Both drivers high impedance (under-voltage latch) |
| discharge_en | output | 1 | Output discharge switch on |

## Verification
The bench holds a flag for one tick fewer than the limit. A filter that counts clocks instead of ticks, or that does not restart, would latch a fault there. It holds `uv_flag` through many ticks before soft-start completes, which exposes missing blanking.

A released over-voltage flag must leave the latch in place. Only dropping `en` or `supply_ok` may clear it. Over- and under-voltage are raised together to expose a wrong priority, which would tristate the drivers instead of clamping the output.

Over-temperature is checked in both directions to catch a latch that should not exist. Power-good is checked at start-up with the output still low, to catch a design that ignores the 90% threshold once soft-start ends.

// File: rtl/conv_supervisor_pkg.sv
package conv_supervisor_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_OV   = 2'd1,
        FLT_UV   = 2'd2
    } fault_e;

    localparam int IDX_OV  = 0;
    localparam int IDX_UV  = 1;
    localparam int IDX_WIN = 2;
    localparam int NCOND   = 3;

    // Over-voltage takes priority: clamping the output beats floating it.
    function automatic fault_e pick_fault(input logic ov_hit, input logic uv_hit);
        if (ov_hit)      return FLT_OV;
        else if (uv_hit) return FLT_UV;
        else             return FLT_NONE;
    endfunction

endpackage

// File: rtl/cs_filter.sv
module cs_filter #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !cond)
            cnt <= '0;
        else if (tick && cnt != W'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == W'(LIMIT));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(LIMIT));
    p_drop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        !cond |=> !hit);
endmodule

// File: rtl/cs_fault_latch.sv
module cs_fault_latch
    import conv_supervisor_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   ov_hit,
    input  logic   uv_hit,
    output fault_e fault_q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            fault_q <= FLT_NONE;
        else if (fault_q == FLT_NONE)
            fault_q <= pick_fault(ov_hit, uv_hit);
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && fault_q != FLT_NONE) |=> fault_q == $past(fault_q));
    p_ov_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (!clr && fault_q == FLT_NONE && ov_hit) |=> fault_q == FLT_OV);
endmodule

// File: rtl/conv_supervisor.sv
module conv_supervisor
    import conv_supervisor_pkg::*;
#(
    parameter int FILT_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_us,
    input  logic en,
    input  logic supply_ok,
    input  logic ss_done,
    input  logic ov_flag,
    input  logic uv_flag,
    input  logic pg_low_flag,
    input  logic ot_flag,
    output logic pgood,
    output logic switch_en,
    output logic low_on,
    output logic hiz,
    output logic discharge_en
);
    logic             run_ok;
    logic [NCOND-1:0] cond;
    logic [NCOND-1:0] hit;
    fault_e           fault_q;
    logic             run_q, ot_q, pg_q, dis_q;

    assign run_ok        = en & supply_ok;
    assign cond[IDX_OV]  = ov_flag;
    assign cond[IDX_UV]  = uv_flag & ss_done;   // blanked during soft-start
    assign cond[IDX_WIN] = ov_flag | pg_low_flag;

    for (genvar i = 0; i < NCOND; i++) begin : g_filt
        cs_filter #(.LIMIT(FILT_TICKS)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .clr  (!run_ok),
            .tick (tick_us),
            .cond (cond[i]),
            .hit  (hit[i])
        );
    end

    cs_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run_ok),
        .ov_hit  (hit[IDX_OV]),
        .uv_hit  (hit[IDX_UV]),
        .fault_q (fault_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ot_q  <= 1'b0;
            pg_q  <= 1'b0;
            dis_q <= 1'b0;
        end else begin
            run_q <= run_ok;
            ot_q  <= ot_flag;
            pg_q  <= run_ok & ss_done & !hit[IDX_WIN];
            dis_q <= !en;
        end
    end

    assign low_on       = (fault_q == FLT_OV);
    assign hiz          = (fault_q == FLT_UV);
    assign switch_en    = run_q & !ot_q & (fault_q == FLT_NONE);
    assign pgood        = pg_q & (fault_q == FLT_NONE);
    assign discharge_en = dis_q;

    p_no_clash_r4: assert property (@(posedge clk) disable iff (rst)
        !(low_on && hiz));
    p_fault_stops_r5: assert property (@(posedge clk) disable iff (rst)
        (low_on || hiz) |-> (!switch_en && !pgood));
    p_pg_ss_r2: assert property (@(posedge clk) disable iff (rst)
        !ss_done |=> !pgood);
    p_ot_off_r9: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> !switch_en);
    p_disch_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> discharge_en);
endmodule

// File: tb/conv_supervisor_tb.sv
module conv_supervisor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b0, en = 1'b0, supply_ok = 1'b0, ss_done = 1'b0;
    logic ov_flag = 1'b0, uv_flag = 1'b0, pg_low_flag = 1'b0, ot_flag = 1'b0;
    logic pgood, switch_en, low_on, hiz, discharge_en;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    conv_supervisor #(.FILT_TICKS(5)) u_dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .en(en), .supply_ok(supply_ok),
        .ss_done(ss_done), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .pg_low_flag(pg_low_flag), .ot_flag(ot_flag), .pgood(pgood),
        .switch_en(switch_en), .low_on(low_on), .hiz(hiz),
        .discharge_en(discharge_en)
    );

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_us = 1'b1; @(negedge clk);
            tick_us = 1'b0; @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R8 reset pgood", pgood, 1'b0);
        chk("R8 reset switch_en", switch_en, 1'b0);
        chk("R4 reset low_on", low_on, 1'b0);
        chk("R5 reset hiz", hiz, 1'b0);
        chk("R8 reset discharge", discharge_en, 1'b0);
    endtask

    task automatic t_startup;
        en = 1'b1; supply_ok = 1'b1; pg_low_flag = 1'b1;
        ticks(10);
        chk("R2 pgood low before ss_done", pgood, 1'b0);
        chk("R9 switching on", switch_en, 1'b1);
        chk("R8 discharge off", discharge_en, 1'b0);
        ss_done = 1'b1; cyc(3);
        chk("R1 pgood low below 90%", pgood, 1'b0);
        pg_low_flag = 1'b0; cyc(2);
        chk("R1 pgood high in window", pgood, 1'b1);
    endtask

    task automatic t_glitch;
        ov_flag = 1'b1; ticks(4); ov_flag = 1'b0; cyc(2);
        chk("R3 short ov no latch", low_on, 1'b0);
        chk("R3 short ov pgood", pgood, 1'b1);
        ov_flag = 1'b1; ticks(4); ov_flag = 1'b0; cyc(1);
        ov_flag = 1'b1; ticks(1); ov_flag = 1'b0; cyc(2);
        chk("R3 count restarts", low_on, 1'b0);
    endtask

    task automatic t_pg_window;
        pg_low_flag = 1'b1; ticks(5); cyc(1);
        chk("R1 pgood drops", pgood, 1'b0);
        chk("R1 switching unaffected", switch_en, 1'b1);
        pg_low_flag = 1'b0; cyc(2);
        chk("R1 pgood returns", pgood, 1'b1);
    endtask

    task automatic t_ov;
        ov_flag = 1'b1; ticks(5); cyc(1);
        chk("R4 low_on", low_on, 1'b1);
        chk("R4 hiz", hiz, 1'b0);
        chk("R4 switch off", switch_en, 1'b0);
        chk("R4 pgood off", pgood, 1'b0);
        ov_flag = 1'b0; ticks(3);
        chk("R7 ov stays latched", low_on, 1'b1);
        en = 1'b0; cyc(1);
        chk("R7 ov cleared by en", low_on, 1'b0);
        chk("R8 discharge on", discharge_en, 1'b1);
        en = 1'b1; cyc(3);
        chk("R8 discharge off again", discharge_en, 1'b0);
        chk("R1 pgood back after clear", pgood, 1'b1);
    endtask

    task automatic t_uv;
        ss_done = 1'b0; uv_flag = 1'b1; ticks(10);
        chk("R6 uv blanked", hiz, 1'b0);
        chk("R6 switching continues", switch_en, 1'b1);
        ss_done = 1'b1; cyc(1); ticks(5); cyc(1);
        chk("R5 hiz", hiz, 1'b1);
        chk("R5 low_on", low_on, 1'b0);
        chk("R5 switch off", switch_en, 1'b0);
        uv_flag = 1'b0; supply_ok = 1'b0; cyc(1);
        chk("R7 uv cleared by supply", hiz, 1'b0);
        supply_ok = 1'b1; cyc(3);
        chk("R7 switching after clear", switch_en, 1'b1);
    endtask

    task automatic t_ot;
        ot_flag = 1'b1; cyc(1);
        chk("R9 ot stops switching", switch_en, 1'b0);
        chk("R9 no latch", low_on | hiz, 1'b0);
        ot_flag = 1'b0; cyc(1);
        chk("R9 ot releases", switch_en, 1'b1);
    endtask

    task automatic t_prio;
        ov_flag = 1'b1; uv_flag = 1'b1; ticks(5); cyc(1);
        chk("R10 ov wins low_on", low_on, 1'b1);
        chk("R10 ov wins hiz", hiz, 1'b0);
        ov_flag = 1'b0; uv_flag = 1'b0; en = 1'b0; cyc(2);
        chk("R7 cleared", low_on, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset;
        rst = 1'b0; cyc(1);
        t_startup;
        t_glitch;
        t_pg_window;
        t_ov;
        t_uv;
        t_ot;
        t_prio;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule